// File: doc/BRIEF.md
# I2C Register-Pointer Slave

This block is the serial front end of a register bank. It watches an I2C bus that toggles slowly compared with the system clock. It finds START, repeated START and STOP conditions, and it answers to one 7-bit device address. The upper five bits of that address are a parameter. The lower two bits come from a strap input, which the block captures once, in the first clock after reset is released. Toward the register file it presents a byte-wide pointer, a one-cycle write strobe with write data, and a combinational read-data input.

Three transfer forms are recognised:

- **Pointer preset.** The address with the write bit, then one byte. The byte loads the internal pointer if it lies below `REG_COUNT`; otherwise it is refused with a NACK.
- **Register write.** The address with the write bit, a command byte that selects the register (and also loads the pointer), then one data byte. The data byte causes a single write strobe.
- **Register read.** The address with the read bit. The block returns the register at the pointer, MSB first, and the pointer then advances by one, wrapping to 0 after the last register. If the master acknowledges a read byte, the next register follows in the same transfer. A master NACK ends the read.

States of the controller:

| State | Meaning |
|---|---|
| `ST_IDLE` | Bus free. |
| `ST_ADDR` | Shifting in the address byte. |
| `ST_ADDR_ACK` | Acknowledge clock for the address byte. |
| `ST_CMD` | Shifting in the pointer or command byte. |
| `ST_CMD_ACK` | Acknowledge clock for that byte. |
| `ST_DATA` | Shifting in the write data byte. |
| `ST_DATA_ACK` | Acknowledge clock for the data byte. |
| `ST_RD_BIT` | Driving read data. |
| `ST_RD_ACK` | Sampling the master's acknowledge. |
| `ST_SKIP` | Ignoring the bus until the next START or STOP. |

Transitions:

- From any state, a STOP leads to `ST_IDLE` and a START leads to `ST_ADDR`.
- `ST_ADDR` goes to `ST_ADDR_ACK` on an address match and to `ST_SKIP` otherwise.
- `ST_ADDR_ACK` goes to `ST_RD_BIT` for a read and to `ST_CMD` for a write.
- `ST_CMD` goes to `ST_CMD_ACK` for a valid byte and to `ST_SKIP` for an invalid one.
- `ST_CMD_ACK` goes to `ST_DATA`.
- `ST_DATA` goes to `ST_DATA_ACK`.
- `ST_DATA_ACK` goes to `ST_SKIP`.
- `ST_RD_BIT` goes to `ST_RD_ACK` after eight bits.
- `ST_RD_ACK` goes to `ST_RD_BIT` on a master ACK and to `ST_SKIP` on a master NACK.

Top module: `i2c_ptr_slave`

## Requirements
- R1: After reset `sda_oe` is 0, `reg_wr` is 0 and the pointer `reg_addr` is 0.
- R2: The slave acknowledges only the address {ADDR_HI, strap}, where strap is the value of `strap_i` in the first clock after reset. Every other 7-bit address gets no acknowledge, and later changes of `strap_i` have no effect. Bit 0 of the address byte is 1 for a read and 0 for a write.
- R3: After the write address, a byte below REG_COUNT (64 by default) is acknowledged and becomes the pointer.
- R4: A pointer byte of REG_COUNT or above is answered with NACK and leaves the pointer unchanged.
- R5: A transfer that ends with STOP before a full pointer byte has arrived leaves the pointer unchanged.
- R6: A read returns the register at the pointer, MSB first, and then advances the pointer by one, wrapping from REG_COUNT-1 to 0.
- R7: A master ACK after a read byte continues with the next register. A master NACK ends the read, and the slave then leaves SDA released.
- R8: A register write produces exactly one single-cycle `reg_wr` with `reg_addr` equal to the command and `reg_wdata` equal to the data byte. The pointer stays at the command. Any further bytes are NACKed.
- R9: A register write whose command is REG_COUNT or above is NACKed and causes no write.
- R10: A repeated START without a STOP restarts the address phase, so a pointer preset followed by a read works in one transfer.
- R11: A STOP that falls in the same SCL high pulse as a START is ignored, and the transfer continues.
- R12: A STOP at any point returns the slave to idle. A STOP inside a data byte causes no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line (resolved level) |
| strap_i | input | 2 | Low two address bits, captured after reset |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| reg_addr | output | 8 | Register pointer toward the register file |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Combinational read data for `reg_addr` |

## Verification
The hardest case to reach from the ports is a START and a STOP inside one SCL high pulse. An ordinary master never produces it. The bench therefore drives both lines directly: it pulls SDA low and then releases it while SCL stays high. It then checks that the address byte which follows is still acknowledged. The bench also cuts transfers short in the middle of a byte and sweeps every device address and every pointer value, computing the expected register contents arithmetically.

// File: rtl/i2cp_pkg.sv
package i2cp_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_RD_BIT,
        ST_RD_ACK,
        ST_SKIP
    } i2cp_state_e;
endpackage

// File: rtl/i2cp_bus_cond.sv
module i2cp_bus_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_s,
    output logic start_evt,
    output logic stop_evt
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] scl_sync, sda_sync;
    logic scl_q, sda_q, scl_s;
    logic start_in_high;
    logic stop_raw;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sync      <= '1;
            sda_sync      <= '1;
            scl_q         <= 1'b1;
            sda_q         <= 1'b1;
            start_in_high <= 1'b0;
        end else begin
            scl_sync <= {scl_sync[LAST-1:0], scl_i};
            sda_sync <= {sda_sync[LAST-1:0], sda_i};
            scl_q    <= scl_s;
            sda_q    <= sda_s;
            if (start_evt)
                start_in_high <= 1'b1;
            else if (scl_fall)
                start_in_high <= 1'b0;
        end
    end

    always_comb begin
        scl_s     = scl_sync[LAST];
        sda_s     = sda_sync[LAST];
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_evt = scl_q & scl_s & sda_q & ~sda_s;
        stop_raw  = scl_q & scl_s & ~sda_q & sda_s;
        stop_evt  = stop_raw & ~start_in_high;
    end

    // R11: a STOP cannot follow a START while SCL has stayed high
    assert_no_stop_same_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(start_evt) && scl_s && scl_q) |-> !stop_evt);
endmodule

// File: rtl/i2cp_fsm.sv
module i2cp_fsm
    import i2cp_pkg::*;
#(
    parameter int REG_COUNT = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       sda_s,
    input  logic       start_evt,
    input  logic       stop_evt,
    input  logic [6:0] dev_addr,
    input  logic [7:0] reg_rdata,
    output logic       sda_oe,
    output logic [7:0] reg_addr,
    output logic       reg_wr,
    output logic [7:0] reg_wdata
);
    localparam int LAST_REG = REG_COUNT - 1;

    i2cp_state_e state, state_n;
    logic [2:0]  bitcnt, bitcnt_n;
    logic [7:0]  shreg, shreg_n, new_byte;
    logic [7:0]  ptr, ptr_n;
    logic        ack_on, ack_on_n;
    logic        wr_q, wr_n;
    logic [7:0]  wdata_q, wdata_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bitcnt  <= '0;
            shreg   <= '0;
            ptr     <= '0;
            ack_on  <= 1'b0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
        end else begin
            state   <= state_n;
            bitcnt  <= bitcnt_n;
            shreg   <= shreg_n;
            ptr     <= ptr_n;
            ack_on  <= ack_on_n;
            wr_q    <= wr_n;
            wdata_q <= wdata_n;
        end
    end

    always_comb begin
        state_n  = state;
        bitcnt_n = bitcnt;
        shreg_n  = shreg;
        ptr_n    = ptr;
        ack_on_n = ack_on;
        wr_n     = 1'b0;
        wdata_n  = wdata_q;
        new_byte = {shreg[6:0], sda_s};
        if (stop_evt) begin
            state_n  = ST_IDLE;
            ack_on_n = 1'b0;
        end else if (start_evt) begin
            state_n  = ST_ADDR;
            bitcnt_n = '0;
            ack_on_n = 1'b0;
        end else begin
            unique case (state)
                ST_IDLE, ST_SKIP: ;
                ST_ADDR: if (scl_rise) begin
                    shreg_n  = new_byte;
                    bitcnt_n = 3'(bitcnt + 3'd1);
                    if (bitcnt == 3'd7)
                        state_n = (new_byte[7:1] == dev_addr) ? ST_ADDR_ACK : ST_SKIP;
                end
                ST_CMD: if (scl_rise) begin
                    shreg_n  = new_byte;
                    bitcnt_n = 3'(bitcnt + 3'd1);
                    if (bitcnt == 3'd7) begin
                        if (int'(new_byte) < REG_COUNT) begin
                            ptr_n   = new_byte;
                            state_n = ST_CMD_ACK;
                        end else begin
                            state_n = ST_SKIP;
                        end
                    end
                end
                ST_DATA: if (scl_rise) begin
                    shreg_n  = new_byte;
                    bitcnt_n = 3'(bitcnt + 3'd1);
                    if (bitcnt == 3'd7) begin
                        wr_n    = 1'b1;
                        wdata_n = new_byte;
                        state_n = ST_DATA_ACK;
                    end
                end
                ST_ADDR_ACK, ST_CMD_ACK, ST_DATA_ACK: if (scl_fall) begin
                    if (!ack_on) begin
                        ack_on_n = 1'b1;
                    end else begin
                        ack_on_n = 1'b0;
                        bitcnt_n = '0;
                        if (state == ST_ADDR_ACK && shreg[0]) begin
                            state_n = ST_RD_BIT;
                            shreg_n = reg_rdata;
                        end else if (state == ST_ADDR_ACK) begin
                            state_n = ST_CMD;
                        end else if (state == ST_CMD_ACK) begin
                            state_n = ST_DATA;
                        end else begin
                            state_n = ST_SKIP;
                        end
                    end
                end
                ST_RD_BIT: if (scl_fall) begin
                    if (bitcnt == 3'd7) begin
                        state_n  = ST_RD_ACK;
                        bitcnt_n = '0;
                    end else begin
                        shreg_n  = {shreg[6:0], 1'b0};
                        bitcnt_n = 3'(bitcnt + 3'd1);
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        ptr_n    = (int'(ptr) == LAST_REG) ? 8'd0 : 8'(ptr + 8'd1);
                        ack_on_n = ~sda_s;
                    end else if (scl_fall) begin
                        ack_on_n = 1'b0;
                        if (ack_on) begin
                            state_n = ST_RD_BIT;
                            shreg_n = reg_rdata;
                        end else begin
                            state_n = ST_SKIP;
                        end
                    end
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        sda_oe    = 1'b0;
        if (state == ST_ADDR_ACK || state == ST_CMD_ACK || state == ST_DATA_ACK)
            sda_oe = ack_on;
        else if (state == ST_RD_BIT)
            sda_oe = ~shreg[7];
        reg_addr  = ptr;
        reg_wr    = wr_q;
        reg_wdata = wdata_q;
    end

    assert_wr_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);
    assert_wr_from_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> ($past(state) == ST_DATA));
    assert_ptr_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(reg_addr) < REG_COUNT);
    assert_idle_ptr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> $stable(reg_addr));
    assert_release_on_stop_R12: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_oe);
    assert_restart_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_evt && !stop_evt) |=> (state == ST_ADDR));
endmodule

// File: rtl/i2c_ptr_slave.sv
module i2c_ptr_slave #(
    parameter logic [4:0] ADDR_HI   = 5'b10100,
    parameter int         REG_COUNT = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [1:0] strap_i,
    output logic       sda_oe,
    output logic [7:0] reg_addr,
    output logic       reg_wr,
    output logic [7:0] reg_wdata,
    input  logic [7:0] reg_rdata
);
    logic [1:0] strap_q;
    logic       strap_done;
    logic       scl_rise, scl_fall, sda_s, start_evt, stop_evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strap_q    <= '0;
            strap_done <= 1'b0;
        end else if (!strap_done) begin
            strap_q    <= strap_i;
            strap_done <= 1'b1;
        end
    end

    assert_strap_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        strap_done |=> $stable(strap_q));

    i2cp_bus_cond #(.SYNC_STAGES(2)) u_cond (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
        .start_evt(start_evt), .stop_evt(stop_evt)
    );

    i2cp_fsm #(.REG_COUNT(REG_COUNT)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_s(sda_s), .start_evt(start_evt), .stop_evt(stop_evt),
        .dev_addr({ADDR_HI, strap_q}), .reg_rdata(reg_rdata),
        .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata)
    );
endmodule

// File: tb/i2c_ptr_slave_tb.sv
module i2c_ptr_slave_tb;
    localparam int CLK_PERIOD = 10;
    localparam int H          = 4;
    localparam int NREG       = 64;
    localparam logic [6:0] DEV = 7'h52;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic [1:0] strap = 2'b10;
    logic sda_oe, reg_wr;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic [7:0] mem [NREG];
    logic sda_line;
    int n_chk = 0, n_fail = 0;
    int wr_count = 0, wide_err = 0;
    logic [7:0] last_waddr = '0, last_wdata = '0;
    logic prev_wr = 1'b0;

    assign sda_line  = sda_m & ~sda_oe;
    assign reg_rdata = mem[reg_addr[5:0]];

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_ptr_slave #(.ADDR_HI(5'b10100), .REG_COUNT(NREG)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .strap_i(strap),
        .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    function automatic logic [7:0] init_val(int i);
        return 8'((i * 37 + 5) & 8'hFF);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem[i] <= init_val(i);
        end else if (reg_wr) begin
            mem[reg_addr[5:0]] <= reg_wdata;
        end
    end

    always @(posedge clk) begin
        prev_wr <= reg_wr;
        if (rst_n && reg_wr) begin
            wr_count   <= wr_count + 1;
            last_waddr <= reg_addr;
            last_wdata <= reg_wdata;
            if (prev_wr) wide_err <= wide_err + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; tick(H);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b0; tick(H);
        scl_m = 1'b0; tick(H);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; tick(H);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b1; tick(H);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; tick(H);
            scl_m = 1'b1; tick(H);
            scl_m = 1'b0; tick(H);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1'b1; tick(H);
        scl_m = 1'b1; tick(H);
        ack = ~sda_line;
        scl_m = 1'b0; tick(H);
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(H);
            scl_m = 1'b1; tick(H);
            b[i] = sda_line;
            scl_m = 1'b0;
        end
        tick(H);
        sda_m = ~mack; tick(H);
        scl_m = 1'b1; tick(H);
        scl_m = 1'b0; tick(H);
        sda_m = 1'b1;
    endtask

    task automatic set_ptr(input logic [7:0] p, output logic a, output logic d);
        bus_start;
        send_byte({DEV, 1'b0}, a);
        send_byte(p, d);
        bus_stop;
    endtask

    task automatic read1(output logic [7:0] v);
        logic a;
        bus_start;
        send_byte({DEV, 1'b1}, a);
        recv_byte(1'b0, v);
        bus_stop;
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        summary;
        $finish;
    end

    initial begin
        logic a, d;
        logic [7:0] v;
        int w0;
        tick(5);
        rst_n = 1'b1;
        tick(3);
        // R1 reset state
        chk("R1 sda_oe", sda_oe, 0);
        chk("R1 reg_wr", reg_wr, 0);
        chk("R1 reg_addr", reg_addr, 0);

        // R2 address sweep
        for (int ad = 0; ad < 128; ad++) begin
            bus_start;
            send_byte({7'(ad), 1'b0}, a);
            bus_stop;
            chk("R2 address ack", a, (7'(ad) == DEV));
        end

        // R3 and R6: every pointer, then read twice
        for (int p = 0; p < NREG; p++) begin
            set_ptr(8'(p), a, d);
            chk("R3 pointer ack", d, 1);
            read1(v);
            chk("R6 read at pointer", v, init_val(p));
            read1(v);
            chk("R6 read after increment", v, init_val((p + 1) % NREG));
        end

        // R4 invalid pointer
        set_ptr(8'd9, a, d);
        set_ptr(8'd64, a, d);
        chk("R4 nack 64", d, 0);
        set_ptr(8'd255, a, d);
        chk("R4 nack 255", d, 0);
        read1(v);
        chk("R4 pointer kept", v, init_val(9));

        // R5 STOP before full pointer byte
        set_ptr(8'd12, a, d);
        bus_start;
        send_byte({DEV, 1'b0}, a);
        send_bits(8'h05, 3);
        bus_stop;
        read1(v);
        chk("R5 partial byte keeps pointer", v, init_val(12));
        bus_start;
        send_byte({DEV, 1'b0}, a);
        bus_stop;
        read1(v);
        chk("R5 address-only keeps pointer", v, init_val(13));

        // R7 multi-byte read with wrap (R6)
        set_ptr(8'd62, a, d);
        bus_start;
        send_byte({DEV, 1'b1}, a);
        recv_byte(1'b1, v);
        chk("R7 first", v, init_val(62));
        recv_byte(1'b1, v);
        chk("R7 second", v, init_val(63));
        recv_byte(1'b0, v);
        chk("R6 wrap to 0", v, init_val(0));
        tick(2 * H);
        chk("R7 released after nack", sda_oe, 0);
        bus_stop;
        read1(v);
        chk("R7 pointer after", v, init_val(1));

        // R8 write-word
        w0 = wr_count;
        bus_start;
        send_byte({DEV, 1'b0}, a);
        send_byte(8'd30, a);
        chk("R8 cmd ack", a, 1);
        send_byte(8'hA5, d);
        chk("R8 data ack", d, 1);
        send_byte(8'h5A, d);
        chk("R8 extra byte nack", d, 0);
        bus_stop;
        chk("R8 one strobe", wr_count, w0 + 1);
        chk("R8 write addr", last_waddr, 30);
        chk("R8 write data", last_wdata, 8'hA5);
        chk("R8 strobe width", wide_err, 0);
        read1(v);
        chk("R8 readback at command", v, 8'hA5);

        // R9 invalid command
        w0 = wr_count;
        bus_start;
        send_byte({DEV, 1'b0}, a);
        send_byte(8'd70, a);
        chk("R9 cmd nack", a, 0);
        send_byte(8'h11, d);
        bus_stop;
        chk("R9 no write", wr_count, w0);

        // R12 STOP inside data byte
        w0 = wr_count;
        bus_start;
        send_byte({DEV, 1'b0}, a);
        send_byte(8'd40, a);
        send_bits(8'hFF, 4);
        bus_stop;
        chk("R12 no write", wr_count, w0);
        chk("R12 released", sda_oe, 0);
        read1(v);
        chk("R12 later read", v, init_val(40));

        // R10 repeated START
        bus_start;
        send_byte({DEV, 1'b0}, a);
        send_byte(8'd20, a);
        bus_start;
        send_byte({DEV, 1'b1}, a);
        chk("R10 read address ack", a, 1);
        recv_byte(1'b0, v);
        bus_stop;
        chk("R10 data", v, init_val(20));

        // R11 START and STOP in one SCL high pulse
        sda_m = 1'b1; scl_m = 1'b1; tick(H);
        sda_m = 1'b0; tick(H);
        sda_m = 1'b1; tick(H);
        scl_m = 1'b0; tick(H);
        send_byte({DEV, 1'b0}, a);
        chk("R11 transfer continues", a, 1);
        send_byte(8'd5, d);
        bus_stop;
        read1(v);
        chk("R11 pointer loaded", v, init_val(5));

        // R2 strap change ignored
        strap = 2'b01;
        tick(4);
        bus_start;
        send_byte({7'h51, 1'b0}, a);
        bus_stop;
        chk("R2 new strap ignored", a, 0);
        bus_start;
        send_byte({DEV, 1'b0}, a);
        bus_stop;
        chk("R2 old address kept", a, 1);

        summary;
        $finish;
    end
endmodule